// File: doc/BRIEF.md
# Timestamped Sample Cluster Unpacker

This block rebuilds a continuous 16-bit logic-sample stream from a captured memory image. The image arrives as 16-bit words in chunks of 512 words. Each chunk holds 64 clusters of eight words. The first word of a cluster is a timestamp and the other seven are event words. Each event word carries one, two or four time-ordered samples, depending on the capture mode. In the slower modes all sixteen probes are captured. The faster modes keep only eight or four probes and pack several samples of each probe into one word. Gaps in the capture appear only as jumps between timestamps. The block fills each gap by repeating the last sample it emitted.

A controller first sets the mode, the first-chunk flag, a timestamp limit and the trigger settings. It then pulses `start` while `idle` is high and streams in the 512 words of the chunk. A final chunk may be only partly filled. For that chunk the controller gives a nonzero limit, and the block stops producing samples at the first cluster whose timestamp is past that limit. It still consumes the rest of the chunk. Inside one selected cluster the block flags the exact sample at which the trigger pattern is first seen.

The block steps through six named states:
- Idle: waits for `start`.
- Stamp: takes the timestamp word.
- Events: takes the seven event words.
- Pad: repeats the last sample to fill a gap.
- Emit: sends the cluster's own samples.
- Drain: discards the words that follow a cluster past the limit.

The transitions are:
- Idle to Stamp when `start` is seen.
- Stamp to Events for a timestamp within the limit, and Stamp to Drain for one past it.
- Events to Pad after the seventh event word if the gap count is nonzero, otherwise Events to Emit.
- Pad to Emit after the last repeated sample.
- Emit to Stamp after the cluster's last sample, or Emit to Idle after the 64th cluster.
- Drain to Idle after the chunk's 512th word.

Top module: `cluster_unpacker`

## Requirements
- R1: After reset, and whenever no chunk is in progress, `idle` is 1 and both `in_ready` and `out_valid` are 0.
- R2: Mode code 0 gives one sample per event (S=1), and each emitted sample equals its event word. Code 3 behaves exactly like code 0.
- R3: Mode code 1 gives S=2. Sample k (k=0,1) of an event has output bit l (l=0..7) equal to event bit 2l+k. Bits 15..8 are zero, and k=0 is emitted before k=1.
- R4: Mode code 2 gives S=4. Sample k (k=0..3) of an event has output bit l (l=0..3) equal to event bit 4l+k. Bits 15..4 are zero, and the samples are emitted in increasing k.
- R5: Let D be the difference, modulo 65536, between a cluster's timestamp and the previous cluster's timestamp. Before the cluster's 7·S samples, the last emitted sample is repeated (D−7)·S times when D>7, and not at all otherwise.
- R6: When `cfg_first` is set, the first cluster gets no repeats and the previous sample starts at zero. When it is clear, the previous timestamp and sample carry over from the prior chunk.
- R7: With a nonzero `cfg_limit`, no samples are emitted for the first cluster whose timestamp exceeds the limit or for any later cluster. A limit of 0 never stops output.
- R8: With `cfg_trig_en` set, the trigger cluster index is floor(max(p−6,0)/7) for mode codes 0 and 3, and floor(p/7) for codes 1 and 2, where p is `cfg_trig_pos`.
- R9: In the trigger cluster, `out_trig` marks the first sample within the first min(8, 7·S) samples that meets three conditions. It must equal the value under the mask. Every rise-mask bit must be 0 in the previous sample and 1 now. Every fall-mask bit must be 1 in the previous sample and 0 now. If no sample in that window matches, the cluster's first sample is marked.
- R10: `in_ready` is never high together with `out_valid`. A stalled output keeps its sample and trigger flag unchanged until it is accepted.
- R11: At most one sample per chunk carries `out_trig`, and `out_trig` is high only together with `out_valid`. With the trigger disabled, no sample is marked.
- R12: A chunk consumes exactly 512 input words, including the words drained after a limit stop, and then `idle` returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a chunk when idle; the configuration is latched at that edge |
| cfg_mode | input | 2 | Samples per event: 0 gives 1, 1 gives 2, 2 gives 4, 3 gives 1 |
| cfg_first | input | 1 | Chunk is the first of a capture |
| cfg_limit | input | 16 | Last timestamp that is still decoded; 0 means no limit |
| cfg_trig_en | input | 1 | Enables trigger marking for this chunk |
| cfg_trig_pos | input | 9 | Trigger event position within the chunk |
| trig_value | input | 16 | Level pattern to match |
| trig_mask | input | 16 | Bits on which the level pattern applies |
| trig_rise | input | 16 | Bits that must rise |
| trig_fall | input | 16 | Bits that must fall |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Block accepts an input word |
| in_word | input | 16 | Chunk word (timestamp or event) |
| out_valid | output | 1 | Output sample valid |
| out_ready | input | 1 | Consumer accepts the sample |
| out_sample | output | 16 | Reconstructed sample |
| out_trig | output | 1 | This sample is the trigger sample |
| idle | output | 1 | No chunk is in progress |

## Verification
A wrong previous-timestamp or previous-sample register shows at the ports as a wrong repeat count or a wrong repeated value. That appears in the first cluster after the fault, so the whole expected sample sequence is compared in order, sample by sample. A wrong mode latch or lane select corrupts the very next emitted sample. A wrong cluster or word counter either shifts where the trigger mark falls or leaves the block out of step with the 512-word chunk, and `idle` then fails to return when the last word is consumed. Trigger placement is checked on crafted data in which the match position is known in advance. Another case has no matching sample, so the fallback mark on the cluster's first sample must appear.

// File: rtl/cu_pkg.sv
package cu_pkg;

    localparam int SMP_W     = 16;
    localparam int EV_PER_CL = 7;
    localparam int IDX_W     = 5;

    typedef logic [EV_PER_CL-1:0][SMP_W-1:0] ev_buf_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_STAMP,
        ST_EVENTS,
        ST_PAD,
        ST_EMIT,
        ST_DRAIN
    } unpack_state_e;

    // log2 of samples per event, from the mode code
    function automatic logic [1:0] mode_shift(logic [1:0] code);
        case (code)
            2'd1:    return 2'd1;
            2'd2:    return 2'd2;
            default: return 2'd0;
        endcase
    endfunction

    // sample n of a cluster: event n>>sh, sub-slot n mod S, probe l at bit l*S+k
    function automatic logic [SMP_W-1:0] pick_sample(ev_buf_t ev, logic [1:0] sh,
                                                     logic [IDX_W-1:0] n);
        logic [IDX_W-1:0] j;
        logic [1:0]       k;
        logic [IDX_W-1:0] lanes;
        logic [SMP_W-1:0] w;
        logic [SMP_W-1:0] r;
        j     = n >> sh;
        k     = n[1:0] & ~(2'b11 << sh);
        lanes = 5'd16 >> sh;
        w     = (j < 5'(EV_PER_CL)) ? ev[j[2:0]] : '0;
        r     = '0;
        for (int l = 0; l < SMP_W; l++) begin
            if (5'(l) < lanes) begin
                r[l] = w[4'(l << sh) | {2'b00, k}];
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/cu_sample_mux.sv
module cu_sample_mux
    import cu_pkg::*;
(
    input  ev_buf_t                 ev,
    input  logic [1:0]              sh,
    input  logic [IDX_W-1:0]        idx,
    output logic [SMP_W-1:0]        smp
);

    always_comb begin
        smp = pick_sample(ev, sh, idx);
    end

endmodule

// File: rtl/cu_gap_calc.sv
module cu_gap_calc
    import cu_pkg::*;
#(
    parameter int TS_W  = 16,
    parameter int PAD_W = TS_W + 2
) (
    input  logic [TS_W-1:0]  ts,
    input  logic [TS_W-1:0]  prev_ts,
    input  logic             first,
    input  logic [1:0]       sh,
    output logic [PAD_W-1:0] pad
);

    localparam logic [TS_W-1:0] SPAN = TS_W'(EV_PER_CL);

    logic [TS_W-1:0] delta;

    always_comb begin
        delta = first ? TS_W'(1) : (ts - prev_ts);
        if (delta > SPAN) begin
            pad = PAD_W'(delta - SPAN) << sh;
        end else begin
            pad = '0;
        end
    end

endmodule

// File: rtl/cu_trig_pick.sv
module cu_trig_pick
    import cu_pkg::*;
#(
    parameter int WIN   = 8,
    parameter int WIN_W = $clog2(WIN)
) (
    input  ev_buf_t              ev,
    input  logic [1:0]           sh,
    input  logic [SMP_W-1:0]     base,
    input  logic [SMP_W-1:0]     value,
    input  logic [SMP_W-1:0]     mask,
    input  logic [SMP_W-1:0]     rise,
    input  logic [SMP_W-1:0]     fall,
    output logic [WIN_W-1:0]     idx
);

    logic [WIN-1:0][SMP_W-1:0] cand;
    logic [WIN-1:0]            hit;
    logic [IDX_W-1:0]          n_smp;

    assign n_smp = 5'(EV_PER_CL) << sh;

    for (genvar g = 0; g < WIN; g++) begin : g_cand
        logic [SMP_W-1:0] prv;
        cu_sample_mux u_mux (
            .ev  (ev),
            .sh  (sh),
            .idx (IDX_W'(g)),
            .smp (cand[g])
        );
        if (g == 0) begin : g_first
            assign prv = base;
        end else begin : g_rest
            assign prv = cand[g-1];
        end
        assign hit[g] = (IDX_W'(g) < n_smp)
                     && ((cand[g] & mask) == (value & mask))
                     && ((prv & rise) == '0) && ((cand[g] & rise) == rise)
                     && ((prv & fall) == fall) && ((cand[g] & fall) == '0);
    end

    always_comb begin
        idx = '0;
        for (int i = WIN - 1; i >= 0; i--) begin
            if (hit[i]) begin
                idx = WIN_W'(i);
            end
        end
    end

endmodule

// File: rtl/cluster_unpacker.sv
module cluster_unpacker
    import cu_pkg::*;
#(
    parameter int CLUSTERS = 64,
    parameter int TRIG_WIN = 8,
    parameter int POS_W    = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        cfg_mode,
    input  logic              cfg_first,
    input  logic [15:0]       cfg_limit,
    input  logic              cfg_trig_en,
    input  logic [POS_W-1:0]  cfg_trig_pos,
    input  logic [15:0]       trig_value,
    input  logic [15:0]       trig_mask,
    input  logic [15:0]       trig_rise,
    input  logic [15:0]       trig_fall,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [15:0]       in_word,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [15:0]       out_sample,
    output logic              out_trig,
    output logic              idle
);

    localparam int CL_W   = $clog2(CLUSTERS);
    localparam int WORDS  = CLUSTERS * (EV_PER_CL + 1);
    localparam int WC_W   = $clog2(WORDS);
    localparam int PAD_W  = SMP_W + 2;
    localparam int TW_W   = $clog2(TRIG_WIN);
    localparam int LEAD   = EV_PER_CL - 1;

    unpack_state_e          state, nxt;

    logic [1:0]             sh_q;
    logic                   first_q;
    logic [15:0]            limit_q;
    logic                   ten_q;
    logic [POS_W-1:0]       tcl_q;
    logic [15:0]            val_q, msk_q, rise_q, fall_q;
    logic [15:0]            prev_ts;
    logic [SMP_W-1:0]       last_smp;
    logic [SMP_W-1:0]       base_smp;
    ev_buf_t                ev_buf;
    logic [2:0]             ev_cnt;
    logic [CL_W-1:0]        cl_cnt;
    logic [WC_W-1:0]        wcnt;
    logic [PAD_W-1:0]       pad_left;
    logic [IDX_W-1:0]       emit_idx;

    logic [PAD_W-1:0]       pad_calc;
    logic [SMP_W-1:0]       cur_smp;
    logic [TW_W-1:0]        trig_idx;
    logic [IDX_W-1:0]       n_smp;
    logic                   in_fire, out_fire;
    logic                   over_limit;
    logic                   last_word, last_ev, last_pad, last_smp_of_cl, last_cl;
    logic                   trig_here;
    logic [POS_W-1:0]       tcl_calc;
    logic [POS_W-1:0]       pos_adj;

    // ---------------------------------------------------------------
    // submodules
    // ---------------------------------------------------------------
    cu_gap_calc #(.TS_W(16), .PAD_W(PAD_W)) u_gap (
        .ts      (in_word),
        .prev_ts (prev_ts),
        .first   (first_q),
        .sh      (sh_q),
        .pad     (pad_calc)
    );

    cu_sample_mux u_emit_mux (
        .ev  (ev_buf),
        .sh  (sh_q),
        .idx (emit_idx),
        .smp (cur_smp)
    );

    cu_trig_pick #(.WIN(TRIG_WIN)) u_trig (
        .ev    (ev_buf),
        .sh    (sh_q),
        .base  (base_smp),
        .value (val_q),
        .mask  (msk_q),
        .rise  (rise_q),
        .fall  (fall_q),
        .idx   (trig_idx)
    );

    // ---------------------------------------------------------------
    // helpers
    // ---------------------------------------------------------------
    always_comb begin
        if (mode_shift(cfg_mode) == 2'd0) begin
            pos_adj = (cfg_trig_pos > POS_W'(LEAD)) ? (cfg_trig_pos - POS_W'(LEAD)) : '0;
        end else begin
            pos_adj = cfg_trig_pos;
        end
        tcl_calc = pos_adj / POS_W'(EV_PER_CL);
    end

    assign n_smp          = 5'(EV_PER_CL) << sh_q;
    assign in_fire        = in_valid && in_ready;
    assign out_fire       = out_valid && out_ready;
    assign over_limit     = (limit_q != '0) && (in_word > limit_q);
    assign last_word      = (wcnt == WC_W'(WORDS - 1));
    assign last_ev        = (ev_cnt == 3'(EV_PER_CL - 1));
    assign last_pad       = (pad_left == PAD_W'(1));
    assign last_smp_of_cl = (emit_idx == n_smp - 5'd1);
    assign last_cl        = (cl_cnt == CL_W'(CLUSTERS - 1));
    assign trig_here      = ten_q && (POS_W'(cl_cnt) == tcl_q);

    // ---------------------------------------------------------------
    // state register
    // ---------------------------------------------------------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // ---------------------------------------------------------------
    // next state
    // ---------------------------------------------------------------
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (start) nxt = ST_STAMP;
            end
            ST_STAMP: begin
                if (in_fire) nxt = over_limit ? ST_DRAIN : ST_EVENTS;
            end
            ST_EVENTS: begin
                if (in_fire && last_ev) nxt = (pad_left != '0) ? ST_PAD : ST_EMIT;
            end
            ST_PAD: begin
                if (out_fire && last_pad) nxt = ST_EMIT;
            end
            ST_EMIT: begin
                if (out_fire && last_smp_of_cl) nxt = last_cl ? ST_IDLE : ST_STAMP;
            end
            ST_DRAIN: begin
                if (in_fire && last_word) nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // ---------------------------------------------------------------
    // outputs
    // ---------------------------------------------------------------
    always_comb begin
        in_ready   = 1'b0;
        out_valid  = 1'b0;
        out_sample = '0;
        out_trig   = 1'b0;
        idle       = 1'b0;
        unique case (state)
            ST_IDLE:   idle = 1'b1;
            ST_STAMP,
            ST_EVENTS,
            ST_DRAIN:  in_ready = 1'b1;
            ST_PAD: begin
                out_valid  = 1'b1;
                out_sample = last_smp;
            end
            ST_EMIT: begin
                out_valid  = 1'b1;
                out_sample = cur_smp;
                out_trig   = trig_here && (emit_idx == IDX_W'(trig_idx));
            end
            default: idle = 1'b1;
        endcase
    end

    // ---------------------------------------------------------------
    // datapath registers
    // ---------------------------------------------------------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q     <= '0;
            first_q  <= 1'b0;
            limit_q  <= '0;
            ten_q    <= 1'b0;
            tcl_q    <= '0;
            val_q    <= '0;
            msk_q    <= '0;
            rise_q   <= '0;
            fall_q   <= '0;
            prev_ts  <= '0;
            last_smp <= '0;
            base_smp <= '0;
            ev_buf   <= '0;
            ev_cnt   <= '0;
            cl_cnt   <= '0;
            wcnt     <= '0;
            pad_left <= '0;
            emit_idx <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        sh_q     <= mode_shift(cfg_mode);
                        first_q  <= cfg_first;
                        limit_q  <= cfg_limit;
                        ten_q    <= cfg_trig_en;
                        tcl_q    <= tcl_calc;
                        val_q    <= trig_value;
                        msk_q    <= trig_mask;
                        rise_q   <= trig_rise;
                        fall_q   <= trig_fall;
                        ev_cnt   <= '0;
                        cl_cnt   <= '0;
                        wcnt     <= '0;
                        emit_idx <= '0;
                        if (cfg_first) last_smp <= '0;
                    end
                end
                ST_STAMP: begin
                    if (in_fire) begin
                        wcnt     <= wcnt + 1'b1;
                        prev_ts  <= in_word;
                        first_q  <= 1'b0;
                        base_smp <= last_smp;
                        pad_left <= pad_calc;
                    end
                end
                ST_EVENTS: begin
                    if (in_fire) begin
                        wcnt           <= wcnt + 1'b1;
                        ev_buf[ev_cnt] <= in_word;
                        ev_cnt         <= last_ev ? 3'd0 : ev_cnt + 3'd1;
                    end
                end
                ST_PAD: begin
                    if (out_fire) pad_left <= pad_left - 1'b1;
                end
                ST_EMIT: begin
                    if (out_fire) begin
                        last_smp <= cur_smp;
                        if (last_smp_of_cl) begin
                            emit_idx <= '0;
                            cl_cnt   <= cl_cnt + 1'b1;
                        end else begin
                            emit_idx <= emit_idx + 1'b1;
                        end
                    end
                end
                ST_DRAIN: begin
                    if (in_fire) wcnt <= wcnt + 1'b1;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/cu_checker.sv
module cu_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic        idle,
    input logic        in_ready,
    input logic        out_valid,
    input logic        out_ready,
    input logic [15:0] out_sample,
    input logic        out_trig
);

    logic trig_seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trig_seen <= 1'b0;
        end else if (idle && start) begin
            trig_seen <= 1'b0;
        end else if (out_valid && out_ready && out_trig) begin
            trig_seen <= 1'b1;
        end
    end

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> (!in_ready && !out_valid));

    p_no_overlap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> !out_valid);

    p_hold_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_sample) && $stable(out_trig)));

    p_trig_once_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_trig) |-> !trig_seen);

    p_trig_valid_r11: assert property (@(posedge clk) disable iff (!rst_n)
        out_trig |-> out_valid);

    p_start_leaves_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && start) |=> !idle);

endmodule

bind cluster_unpacker cu_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .idle       (idle),
    .in_ready   (in_ready),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_sample (out_sample),
    .out_trig   (out_trig)
);

// File: tb/sim_cluster_unpacker.sv
module sim_cluster_unpacker;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  cfg_mode = '0;
    logic        cfg_first = 1'b0;
    logic [15:0] cfg_limit = '0;
    logic        cfg_trig_en = 1'b0;
    logic [8:0]  cfg_trig_pos = '0;
    logic [15:0] trig_value = '0, trig_mask = '0, trig_rise = '0, trig_fall = '0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [15:0] in_word = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [15:0] out_sample;
    logic        out_trig;
    logic        idle;

    always #(CLK_PERIOD / 2) clk = ~clk;

    cluster_unpacker u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_mode(cfg_mode),
        .cfg_first(cfg_first), .cfg_limit(cfg_limit), .cfg_trig_en(cfg_trig_en),
        .cfg_trig_pos(cfg_trig_pos), .trig_value(trig_value), .trig_mask(trig_mask),
        .trig_rise(trig_rise), .trig_fall(trig_fall), .in_valid(in_valid),
        .in_ready(in_ready), .in_word(in_word), .out_valid(out_valid),
        .out_ready(out_ready), .out_sample(out_sample), .out_trig(out_trig),
        .idle(idle)
    );

    int checks = 0;
    int errors = 0;

    logic [15:0] wbuf [512];
    logic [15:0] exp_s[$];
    logic        exp_t[$];
    logic [15:0] got_s[$];
    logic        got_t[$];
    logic [15:0] m_prev = '0;
    logic [15:0] m_last = '0;
    logic [15:0] end_ts = '0;
    int          words_taken;

    task automatic check(string req, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    function automatic logic [15:0] hash(int seed, int c, int j);
        logic [31:0] h;
        h = (32'(seed) * 32'd2654435761) ^ (32'(c) * 32'd40503 + 32'(j) * 32'd7919 + 32'd13);
        h = h ^ (h >> 13);
        return h[15:0];
    endfunction

    task automatic fill(int seed, logic [15:0] base);
        logic [15:0] ts;
        ts = base;
        for (int c = 0; c < 64; c++) begin
            wbuf[c*8] = ts;
            for (int j = 0; j < 7; j++) wbuf[c*8+1+j] = hash(seed, c, j);
            end_ts = ts;
            ts = ts + 16'd7 + ((c % 9 == 4) ? 16'd3 : 16'd0) + ((c == 20) ? 16'd40 : 16'd0);
        end
    endtask

    // independent expectation from the requirements
    task automatic model();
        int s, tcl, win, tix, n;
        logic [15:0] ts, d, v, p;
        logic [15:0] cs [28];
        logic found;
        s = (cfg_mode == 2'd1) ? 2 : (cfg_mode == 2'd2) ? 4 : 1;
        if (s == 1) tcl = (int'(cfg_trig_pos) < 6) ? 0 : (int'(cfg_trig_pos) - 6) / 7;
        else        tcl = int'(cfg_trig_pos) / 7;
        exp_s.delete(); exp_t.delete();
        if (cfg_first) m_last = '0;
        for (int c = 0; c < 64; c++) begin
            ts = wbuf[c*8];
            if (cfg_limit != 0 && ts > cfg_limit) break;
            d = (cfg_first && c == 0) ? 16'd1 : 16'(ts - m_prev);
            m_prev = ts;
            if (d > 7) begin
                for (int r = 0; r < (int'(d) - 7) * s; r++) begin
                    exp_s.push_back(m_last); exp_t.push_back(1'b0);
                end
            end
            n = 7 * s;
            for (int j = 0; j < 7; j++)
                for (int k = 0; k < s; k++) begin
                    v = '0;
                    for (int l = 0; l < 16 / s; l++) v[l] = wbuf[c*8+1+j][l*s+k];
                    cs[j*s+k] = v;
                end
            tix = -1;
            if (cfg_trig_en && c == tcl) begin
                tix = 0; found = 1'b0;
                win = (n < 8) ? n : 8;
                for (int i = 0; i < win; i++) begin
                    p = (i == 0) ? m_last : cs[i-1];
                    if (!found && ((cs[i] & trig_mask) == (trig_value & trig_mask))
                        && ((p & trig_rise) == 0) && ((cs[i] & trig_rise) == trig_rise)
                        && ((p & trig_fall) == trig_fall) && ((cs[i] & trig_fall) == 0)) begin
                        tix = i; found = 1'b1;
                    end
                end
            end
            for (int i = 0; i < n; i++) begin
                exp_s.push_back(cs[i]); exp_t.push_back(i == tix);
            end
            m_last = cs[n-1];
        end
    endtask

    task automatic run_chunk(bit stall);
        int idx, cyc;
        got_s.delete(); got_t.delete();
        idx = 0; cyc = 0;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        forever begin
            if (idle && idx == 512) break;
            out_ready = !stall || (cyc % 3 != 0);
            if (out_valid && out_ready) begin
                got_s.push_back(out_sample); got_t.push_back(out_trig);
            end
            if (idx < 512) begin
                in_valid = 1'b1;
                in_word  = wbuf[idx];
                if (in_ready) idx++;
            end else begin
                in_valid = 1'b0;
            end
            @(negedge clk);
            cyc++;
        end
        in_valid = 1'b0;
        words_taken = idx;
    endtask

    task automatic compare(string req);
        int n;
        check({req, " sample count"}, 32'(got_s.size()), 32'(exp_s.size()));
        n = (got_s.size() < exp_s.size()) ? got_s.size() : exp_s.size();
        for (int i = 0; i < n; i++)
            check(req, {15'd0, got_t[i], got_s[i]}, {15'd0, exp_t[i], exp_s[i]});
    endtask

    function automatic int trig_count();
        int t = 0;
        foreach (got_t[i]) if (got_t[i]) t++;
        return t;
    endfunction

    task automatic t_reset();
        check("R1 idle after reset", 32'(idle), 32'd1);
        check("R1 in_ready after reset", 32'(in_ready), 32'd0);
        check("R1 out_valid after reset", 32'(out_valid), 32'd0);
    endtask

    task automatic t_mode16_first();
        cfg_mode = 2'd0; cfg_first = 1'b1; cfg_limit = '0; cfg_trig_en = 1'b0;
        fill(1, 16'h0100);
        model();
        run_chunk(1'b0);
        compare("R2 R5 R6 mode0 first chunk");
        check("R6 first sample is first event", 32'(got_s[0]), 32'(wbuf[1]));
        check("R11 no trigger when disabled", 32'(trig_count()), 32'd0);
        check("R12 words consumed", 32'(words_taken), 32'd512);
    endtask

    task automatic t_mode8_chain();
        logic [15:0] carry;
        carry = m_last;
        cfg_mode = 2'd1; cfg_first = 1'b0;
        fill(2, end_ts + 16'd27);
        model();
        run_chunk(1'b1);
        compare("R3 R10 mode1 chained with stalls");
        check("R6 carried sample repeated", 32'(got_s[0]), 32'(carry));
    endtask

    task automatic t_mode4_wrap();
        cfg_mode = 2'd2; cfg_first = 1'b1;
        fill(3, 16'hFFE0);
        model();
        run_chunk(1'b0);
        compare("R4 R5 mode2 timestamp wrap");
    endtask

    task automatic t_limit();
        cfg_mode = 2'd0; cfg_first = 1'b1;
        fill(4, 16'h0200);
        cfg_limit = wbuf[10*8];
        model();
        run_chunk(1'b1);
        compare("R7 limit stop");
        check("R7 samples from 11 clusters", 32'(got_s.size()), 32'(exp_s.size()));
        check("R12 drained words", 32'(words_taken), 32'd512);
        check("R12 idle after drain", 32'(idle), 32'd1);
        cfg_limit = '0;
    endtask

    task automatic t_trig_rise();
        int pos;
        cfg_mode = 2'd0; cfg_first = 1'b1; cfg_trig_en = 1'b1; cfg_trig_pos = 9'd100;
        trig_value = '0; trig_mask = '0; trig_rise = 16'h0001; trig_fall = '0;
        fill(5, 16'h0300);
        wbuf[12*8+7] = wbuf[12*8+7] & 16'hFFFE;
        wbuf[13*8+1] = 16'h0010;
        wbuf[13*8+2] = 16'h0020;
        wbuf[13*8+3] = 16'h0001;
        model();
        run_chunk(1'b0);
        compare("R8 R9 rising trigger");
        check("R11 one trigger", 32'(trig_count()), 32'd1);
        pos = -1;
        foreach (got_t[i]) if (got_t[i]) pos = i;
        if (pos >= 0) check("R9 trigger sample value", 32'(got_s[pos]), 32'h0001);
        else          check("R9 trigger present", 32'd0, 32'd1);
    endtask

    task automatic t_trig_nomatch();
        cfg_mode = 2'd1; cfg_first = 1'b1; cfg_trig_en = 1'b1; cfg_trig_pos = 9'd50;
        trig_value = '0; trig_mask = '0; trig_rise = 16'h8000; trig_fall = '0;
        fill(6, 16'h0400);
        model();
        run_chunk(1'b1);
        compare("R9 no match marks first sample");
        check("R11 one fallback trigger", 32'(trig_count()), 32'd1);
    endtask

    task automatic t_mode3_fall();
        cfg_mode = 2'd3; cfg_first = 1'b1; cfg_trig_en = 1'b1; cfg_trig_pos = 9'd3;
        trig_value = 16'h0000; trig_mask = 16'h0100; trig_rise = '0; trig_fall = 16'h0004;
        fill(7, 16'h0500);
        wbuf[1] = 16'h0004;
        wbuf[2] = 16'h0104;
        wbuf[3] = 16'h0000;
        model();
        run_chunk(1'b0);
        compare("R2 R8 mode3 alias, clamped cluster 0, falling");
        check("R9 fall at sample 2", 32'(got_t[2]), 32'd1);
        cfg_trig_en = 1'b0; trig_fall = '0; trig_mask = '0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_mode16_first();
        t_mode8_chain();
        t_mode4_wrap();
        t_limit();
        t_trig_rise();
        t_trig_nomatch();
        t_mode3_fall();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule